// File: doc/BRIEF.md
# Character Port with Paired FIFOs

This block is a bus-slave character port. A processor reaches it through two word-wide registers chosen by a one-bit address. One is a data register and the other is a control/status register. Behind the port sit two 64-entry character queues. The receive queue is filled from a host-side byte stream. The transmit queue is drained into that stream. Both host-side streams use valid/ready byte handshakes.

Software reads characters one at a time. Each read pops one character and also reports how many characters are left. Software writes characters into the transmit queue. A write that arrives when the queue is full is lost without notice. The control register holds the two interrupt enables, shows the pending flags already gated by those enables, and reports how much room the transmit queue has. It also carries a sticky flag that a host-side activity strobe sets and that software clears by writing 1 to it. A single level interrupt combines the two pending conditions.

The bus read word is combinational on `bus_addr`. It is valid in the same cycle that `bus_rd` is high. The pop and all register updates take effect at the following clock edge. The queue depth must be a power of two.

Top module: `char_port`

## Requirements
- R1: A data-register read (`bus_addr`=0) with the receive queue non-empty returns the oldest character in bits [7:0] and sets bit 15 to 1. That character is removed at the clock edge.
- R2: The same data read returns, in bits [31:16], the count left after the pop. A data read on an empty queue returns an all-zero word, with bit 15 = 0, and leaves the queue unchanged.
- R3: A data-register write pushes bits [7:0] into the transmit queue when it holds fewer than 64 entries; otherwise the character is dropped. `tx_valid` is high whenever the transmit queue is non-empty, with `tx_data` showing its oldest entry. An entry leaves the queue on a cycle where `tx_valid` and `tx_ready` are both high.
- R4: Control bit 0 is the receive-interrupt enable and bit 1 is the transmit-interrupt enable. A control write (`bus_addr`=1) loads both, and a control read returns them.
- R5: Control bit 8 reads as (bit 0 AND receive queue non-empty). Control bit 9 reads as (bit 1 AND transmit occupancy at most 16, i.e. a quarter of the depth).
- R6: Control bit 10 is set by `host_act` and stays set until a control write with bit 10 = 1 clears it. If `host_act` is high in the same cycle as that write, the flag stays set.
- R7: Control bits [31:16] report the free entries in the transmit queue (64 minus occupancy).
- R8: `irq` is high exactly when control bit 8 or bit 9 reads as 1.
- R9: `rx_ready` is high while the receive queue holds fewer than 64 entries, and a byte is accepted when `rx_valid` and `rx_ready` are both high. A push and a pop of the same queue in one cycle leave its count unchanged, and no count exceeds 64.
- R10: Reset empties both queues and clears both enables and the activity flag. After reset, a control read gives 0x0040_0000, `irq` = 0, `tx_valid` = 0 and `rx_ready` = 1.
- R11: Writes to read-only or unused control bits have no effect. Unused bits of both registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Register select: 0 data, 1 control |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data (combinational) |
| irq | output | 1 | Level interrupt |
| rx_data | input | 8 | Host byte into the receive queue |
| rx_valid | input | 1 | Host byte valid |
| rx_ready | output | 1 | Receive queue can accept |
| tx_data | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit queue non-empty |
| tx_ready | input | 1 | Host takes transmit byte |
| host_act | input | 1 | Host-side activity strobe |

## Verification
Two events can land in the same cycle on each queue. On the receive queue, a host push can meet a bus pop. On the transmit queue, a bus push can meet a host drain. A third collision is the activity strobe arriving in the same cycle as the software clear. The bench forces each of these collisions directly at the full and empty boundaries, then adds a long stretch of random traffic that produces many more. A queue-based model decides what should be accepted, using the pre-edge occupancy, and the port outputs and read words are compared with it every cycle.

// File: rtl/char_port.sv
module char_port #(
  parameter int DEPTH    = 64,
  parameter int LOW_MARK = DEPTH / 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic        host_act
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] LOW  = CW'(LOW_MARK);

  logic [7:0]    rmem [DEPTH];
  logic [7:0]    wmem [DEPTH];
  logic [AW-1:0] r_wp, r_rp, w_wp, w_rp;
  logic [CW-1:0] r_cnt, w_cnt;
  logic          ie_rd, ie_wr, act_flag;

  logic r_push, r_pop, w_push, w_pop, ctl_wr, pend_rd, pend_wr;
  logic unused_wbits;

  assign r_push = rx_valid && (r_cnt != FULL);
  assign r_pop  = bus_rd && !bus_addr && (r_cnt != '0);
  assign w_push = bus_wr && !bus_addr && (w_cnt != FULL);
  assign w_pop  = tx_ready && (w_cnt != '0);
  assign ctl_wr = bus_wr && bus_addr;

  assign pend_rd = ie_rd && (r_cnt != '0);
  assign pend_wr = ie_wr && (w_cnt <= LOW);
  assign irq     = pend_rd || pend_wr;

  assign rx_ready = (r_cnt != FULL);
  assign tx_valid = (w_cnt != '0);
  assign tx_data  = wmem[w_rp];

  assign unused_wbits = ^{bus_wdata[31:11], bus_wdata[9:8]};

  always_comb begin
    if (bus_addr)
      bus_rdata = {16'(FULL - w_cnt), 5'b0, act_flag, pend_wr, pend_rd, 6'b0, ie_wr, ie_rd};
    else if (r_cnt != '0)
      bus_rdata = {16'(r_cnt - CW'(1)), 1'b1, 7'b0, rmem[r_rp]};
    else
      bus_rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (r_push) rmem[r_wp] <= rx_data;
    if (w_push) wmem[w_wp] <= bus_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_wp <= '0; r_rp <= '0; r_cnt <= '0;
      w_wp <= '0; w_rp <= '0; w_cnt <= '0;
      ie_rd <= 1'b0; ie_wr <= 1'b0; act_flag <= 1'b0;
    end else begin
      if (r_push) r_wp <= r_wp + AW'(1);
      if (r_pop)  r_rp <= r_rp + AW'(1);
      r_cnt <= r_cnt + CW'(r_push) - CW'(r_pop);
      if (w_push) w_wp <= w_wp + AW'(1);
      if (w_pop)  w_rp <= w_rp + AW'(1);
      w_cnt <= w_cnt + CW'(w_push) - CW'(w_pop);
      if (ctl_wr) begin
        ie_rd <= bus_wdata[0];
        ie_wr <= bus_wdata[1];
      end
      if (host_act)                    act_flag <= 1'b1;
      else if (ctl_wr && bus_wdata[10]) act_flag <= 1'b0;
    end
  end

  assert_pop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    r_pop && !r_push |=> r_cnt == $past(r_cnt) - CW'(1));
  assert_empty_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_addr && r_cnt == '0 && !rx_valid |=> r_cnt == '0);
  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_addr && w_cnt == FULL && !tx_ready |=> w_cnt == FULL);
  assert_sticky_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_act |=> act_flag);
  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act_flag && !(ctl_wr && bus_wdata[10]) |=> act_flag);
  assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_rd && !ie_wr |-> !irq);
  assert_irq_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (r_cnt != '0) || (w_cnt <= LOW));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    r_cnt <= FULL && w_cnt <= FULL);
  assert_push_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    r_push && r_pop |=> $stable(r_cnt));
endmodule

// File: tb/char_port_tb.sv
module char_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_addr = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic        host_act = 1'b0;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] rq[$];
  logic [7:0] wq[$];
  bit m_re = 0, m_we = 0, m_ac = 0;
  bit done = 0;

  always #4 clk = ~clk;

  char_port u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit a, bit rd, bit wr, logic [31:0] wd, bit rxv, logic [7:0] rxd, bit txr, bit act);
    int rs, ws;
    bit ri, wi;
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    rx_valid = rxv; rx_data = rxd; tx_ready = txr; host_act = act;
    #1;
    rs = rq.size(); ws = wq.size();
    ri = m_re && rs > 0;
    wi = m_we && ws <= 16;
    chk("R8 irq", {31'b0, irq}, {31'b0, ri || wi});
    chk("R9 rx_ready", {31'b0, rx_ready}, {31'b0, rs < 64});
    chk("R3 tx_valid", {31'b0, tx_valid}, {31'b0, ws > 0});
    if (ws > 0) chk("R3 tx_data", {24'b0, tx_data}, {24'b0, wq[0]});
    if (rd && !a) begin
      if (rs > 0) begin
        chk("R1 char+valid", {16'b0, bus_rdata[15], 7'b0, bus_rdata[7:0]}, {16'b0, 1'b1, 7'b0, rq[0]});
        chk("R2 remaining", {16'b0, bus_rdata[31:16]}, 32'(rs - 1));
        chk("R11 data zero bits", {25'b0, bus_rdata[14:8]}, 32'b0);
      end else
        chk("R2 empty read", bus_rdata, 32'b0);
    end
    if (rd && a) begin
      chk("R4 enables", {30'b0, bus_rdata[1:0]}, {30'b0, m_we, m_re});
      chk("R5 pending", {30'b0, bus_rdata[9:8]}, {30'b0, wi, ri});
      chk("R6 activity", {31'b0, bus_rdata[10]}, {31'b0, m_ac});
      chk("R7 free", {16'b0, bus_rdata[31:16]}, 32'(64 - ws));
      chk("R11 ctrl zero bits", {21'b0, bus_rdata[15:11], bus_rdata[7:2]}, 32'b0);
    end
    @(posedge clk);
    if (rd && !a && rs > 0) void'(rq.pop_front());
    if (rxv && rs < 64) rq.push_back(rxd);
    if (txr && ws > 0) void'(wq.pop_front());
    if (wr && !a && ws < 64) wq.push_back(wd[7:0]);
    if (wr && a) begin m_re = wd[0]; m_we = wd[1]; end
    if (act) m_ac = 1;
    else if (wr && a && wd[10]) m_ac = 0;
    @(negedge clk);
  endtask

  task automatic rd_ctl(); step(1, 1, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_addr = 1'b1; #1;
    chk("R10 ctrl after reset", bus_rdata, 32'h0040_0000);
    chk("R10 irq", {31'b0, irq}, 32'b0);
    chk("R10 tx_valid", {31'b0, tx_valid}, 32'b0);
    chk("R10 rx_ready", {31'b0, rx_ready}, 32'b1);
    @(negedge clk);
    rd_ctl();
    step(0, 1, 0, 0, 0, 0, 0, 0);            // R2 empty read
    step(1, 0, 1, 32'hFFFF_FBFF, 0, 0, 0, 0); // R11 all but bit10 written
    rd_ctl();
    // R3 fill transmit queue past full
    for (int i = 0; i < 70; i++) step(0, 0, 1, 32'hABCD_0000 | i, 0, 0, 0, 0);
    rd_ctl();
    // R3 push and drain in the same cycle at full
    step(0, 0, 1, 32'h0000_00EE, 0, 0, 1, 0);
    rd_ctl();
    for (int i = 0; i < 60; i++) step(0, 0, 0, 0, 0, 0, 1, 0);
    rd_ctl();
    // R9 fill receive queue past full
    for (int i = 0; i < 70; i++) step(0, 0, 0, 0, 1, 8'(i + 3), 0, 0);
    step(0, 1, 0, 0, 1, 8'h55, 0, 0);        // R9 push with pop at full
    step(0, 1, 0, 0, 1, 8'h66, 0, 0);        // R9 push with pop
    for (int i = 0; i < 70; i++) step(0, 1, 0, 0, 0, 0, 0, 0);
    rd_ctl();
    // R6 sticky flag
    step(1, 0, 0, 0, 0, 0, 0, 1);
    rd_ctl();
    step(1, 0, 1, 32'h0000_0403, 0, 0, 0, 1); // clear meets strobe
    rd_ctl();
    step(1, 0, 1, 32'h0000_0400, 0, 0, 0, 0); // clear, enables off
    rd_ctl();
    step(1, 0, 1, 32'h0000_0003, 0, 0, 0, 0);
    for (int i = 0; i < 6000; i++) begin
      bit a, rd, wr;
      int k;
      logic [31:0] wd;
      k  = $urandom_range(0, 9);
      a  = (k >= 8);
      rd = (k inside {0, 1, 2, 8});
      wr = (k inside {3, 4, 5, 9});
      wd = $urandom;
      if (a) wd[10] = ($urandom_range(0, 3) == 0);
      step(a, rd, wr, wd, $urandom_range(0, 2) != 0, 8'($urandom),
           $urandom_range(0, 2) == 0, $urandom_range(0, 15) == 0);
    end
    rd_ctl();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule